// File: doc/BRIEF.md
# Serial EEPROM Page-Write Target

This block is the write side of a two-wire serial memory target for a 1024 x 8 non-volatile array. It watches the bus clock and data lines through synchronisers running on the system clock, recognises Start and Stop conditions, and decodes three kinds of byte frame. The first is a select byte that names the device and carries the two upper address bits. The second is an address byte that gives the low eight address bits. Any further bytes are data.

Data bytes are held in a 16-entry page buffer. The buffer is copied to the array through a plain write port only when the master closes the transfer with a Stop in the first bit slot after an acknowledged data byte. The copy starts a programming period of a fixed number of system clocks. While that period runs, the block neither drives the bus nor reacts to it. A write-control input can block a whole transfer. If it is high at any time from the Start up to the end of the address byte, every data byte is refused and the array is left alone.

Top module: `eepromPageWriter`

## Requirements
- R1: A select byte is acknowledged only when its bits 7:4 are 1010 and its bit 0 (direction) is 0. Bit 3 is ignored. Any other select byte is refused, and so is every byte that follows it until the next Start.
- R2: After an accepted select byte, the address byte is acknowledged. The target address is {select bit 2, select bit 1, address byte}.
- R3: When writes are allowed, every data byte is acknowledged and buffered at the current address. The low 4 address bits then advance by one and wrap inside the 16-byte page, so a later byte to the same offset replaces the earlier one.
- R4: Each buffered offset is written exactly once through the write port, in ascending offset order, one write per clock, early in the programming period. This happens only after a Stop that lands in the first bit slot after an acknowledged data byte. A Stop right after the address acknowledge does not start a write.
- R5: A Stop in any other bit slot ends the transfer with no array write and no programming period.
- R6: If write control is high at any time from the Start to the end of the address byte's eighth bit, every data byte is refused. The closing Stop then starts no write.
- R7: Write control raised only after the address byte has no effect. Data bytes are still acknowledged and committed.
- R8: The busy output is high for exactly WRITE_CYCLES system clocks after a committing Stop. During that time the data line is never pulled low and no select byte is acknowledged.
- R9: The data line is pulled low only during an acknowledge slot. The pull is applied and removed only while the bus clock is low. Out of reset, the busy output, the data-line pull and the write strobe are all inactive.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low asynchronous reset |
| sclIn | input | 1 | Bus clock line, as seen at the pad |
| sdaIn | input | 1 | Bus data line, as seen at the pad |
| wcIn | input | 1 | Write control; high blocks writes |
| sdaOutLow | output | 1 | 1 pulls the data line low, 0 releases it |
| busy | output | 1 | High during the programming period |
| memWe | output | 1 | Array write strobe |
| memAddr | output | ADDR_W | Array write address |
| memData | output | 8 | Array write data |

## Verification
The bench drives transfers that include a single-byte write, a short page write, and a page write long enough to wrap and overwrite earlier offsets. Together these separate plain buffering from the wrap-and-replace behaviour and the fixed ascending commit order. Stops placed mid-byte and right after the address acknowledge are set against Stops placed after a data acknowledge, which isolates the one slot that commits. Three write-control patterns are tried: held high through the header, pulsed during the select byte, and raised only during data. These show where the inhibit window ends. A select byte sent during the programming period, along with wrong-code and read-direction select bytes, shows when the target stays silent.

// File: rtl/eeprom_wr_pkg.sv
package eeprom_wr_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_SEL,
    ST_ADDR,
    ST_DATA,
    ST_BUSY
  } ctlState_t;

  // bus conditions seen after synchronisation
  typedef struct packed {
    logic sclRise;
    logic sclFall;
    logic start;
    logic stop;
  } busEv_t;

  // strobes from control to datapath
  typedef struct packed {
    logic shiftBit;
    logic loadSel;
    logic loadAddr;
    logic storeByte;
    logic commitStep;
  } dpStrobe_t;

endpackage

// File: rtl/eepromWrDatapath.sv
module eepromWrDatapath
  import eeprom_wr_pkg::*;
#(
  parameter int ADDR_W     = 10,
  parameter int PAGE_BYTES = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              sclIn,
  input  logic              sdaIn,
  input  dpStrobe_t         strobe,
  output busEv_t            busEv,
  output logic [7:0]        rxByte,
  output logic              memWe,
  output logic [ADDR_W-1:0] memAddr,
  output logic [7:0]        memData
);
  localparam int OFF_W  = $clog2(PAGE_BYTES);
  localparam int HI_W   = ADDR_W - 8;
  localparam int BASE_W = ADDR_W - OFF_W;
  localparam int LINES  = 2;

  // two-flop synchroniser plus one history flop per bus line
  logic [LINES-1:0] rawLine;
  logic [LINES-1:0] syncLine;
  logic [LINES-1:0] prevLine;
  assign rawLine = {sclIn, sdaIn};

  for (genvar g = 0; g < LINES; g++) begin : gSync
    logic meta, stable, hist;
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        meta   <= 1'b1;
        stable <= 1'b1;
        hist   <= 1'b1;
      end else begin
        meta   <= rawLine[g];
        stable <= meta;
        hist   <= stable;
      end
    end
    assign syncLine[g] = stable;
    assign prevLine[g] = hist;
  end

  logic sclS, sclP, sdaS, sdaP;
  assign sclS = syncLine[1];
  assign sclP = prevLine[1];
  assign sdaS = syncLine[0];
  assign sdaP = prevLine[0];

  assign busEv.sclRise = sclS & ~sclP;
  assign busEv.sclFall = ~sclS & sclP;
  assign busEv.start   = sclS & sclP & sdaP & ~sdaS;
  assign busEv.stop    = sclS & sclP & ~sdaP & sdaS;

  // shift register for the incoming frame
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) rxByte <= '0;
    else if (strobe.shiftBit) rxByte <= {rxByte[6:0], sdaS};
  end

  // address registers
  logic [HI_W-1:0]   hiAddr;
  logic [BASE_W-1:0] pageBase;
  logic [OFF_W-1:0]  wrOff;
  logic [OFF_W-1:0]  commitIdx;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      hiAddr    <= '0;
      pageBase  <= '0;
      wrOff     <= '0;
      commitIdx <= '0;
    end else begin
      if (strobe.loadSel) hiAddr <= rxByte[HI_W:1];
      if (strobe.loadAddr) begin
        pageBase  <= {hiAddr, rxByte[7:OFF_W]};
        wrOff     <= rxByte[OFF_W-1:0];
        commitIdx <= '0;
      end else begin
        if (strobe.storeByte) wrOff <= wrOff + 1'b1;
        if (strobe.commitStep) commitIdx <= commitIdx + 1'b1;
      end
    end
  end

  // page buffer
  logic [7:0]            slotData [PAGE_BYTES];
  logic [PAGE_BYTES-1:0] slotValid;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      slotValid <= '0;
      for (int i = 0; i < PAGE_BYTES; i++) slotData[i] <= '0;
    end else if (strobe.loadAddr) begin
      slotValid <= '0;
    end else if (strobe.storeByte) begin
      slotData[wrOff]  <= rxByte;
      slotValid[wrOff] <= 1'b1;
    end
  end

  // commit sequencer output stage
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      memWe   <= 1'b0;
      memAddr <= '0;
      memData <= '0;
    end else if (strobe.commitStep) begin
      memWe   <= slotValid[commitIdx];
      memAddr <= {pageBase, commitIdx};
      memData <= slotData[commitIdx];
    end else begin
      memWe <= 1'b0;
    end
  end

endmodule

// File: rtl/eepromWrControl.sv
module eepromWrControl
  import eeprom_wr_pkg::*;
#(
  parameter int          WRITE_CYCLES = 625000,
  parameter int          PAGE_BYTES   = 16,
  parameter logic [3:0]  DEV_CODE     = 4'b1010
) (
  input  logic       clk,
  input  logic       rstN,
  input  busEv_t     busEv,
  input  logic [7:0] rxByte,
  input  logic       wcIn,
  output dpStrobe_t  strobe,
  output logic       sdaOutLow,
  output logic       busy
);
  localparam int BUSY_W = $clog2(WRITE_CYCLES);
  localparam logic [BUSY_W-1:0] LAST_CNT = BUSY_W'(WRITE_CYCLES - 1);
  localparam logic [BUSY_W-1:0] STEP_CNT = BUSY_W'(PAGE_BYTES);

  ctlState_t         state;
  logic [3:0]        bitCnt;
  logic              wcBlock;
  logic              lastAck;
  logic [BUSY_W-1:0] busyCnt;

  logic inFrame, byteDone, ackDone, selOk, ackNext;

  assign inFrame  = (state == ST_SEL) || (state == ST_ADDR) || (state == ST_DATA);
  assign byteDone = inFrame && busEv.sclFall && (bitCnt == 4'd8);
  assign ackDone  = inFrame && busEv.sclFall && (bitCnt == 4'd9);
  assign selOk    = (rxByte[7:4] == DEV_CODE) && !rxByte[0];

  always_comb begin
    unique case (state)
      ST_SEL:  ackNext = selOk;
      ST_ADDR: ackNext = 1'b1;
      ST_DATA: ackNext = !wcBlock;
      default: ackNext = 1'b0;
    endcase
  end

  always_comb begin
    strobe            = '0;
    strobe.shiftBit   = inFrame && busEv.sclRise && (bitCnt < 4'd8);
    strobe.loadSel    = byteDone && (state == ST_SEL) && selOk;
    strobe.loadAddr   = byteDone && (state == ST_ADDR);
    strobe.storeByte  = byteDone && (state == ST_DATA) && !wcBlock;
    strobe.commitStep = (state == ST_BUSY) && (busyCnt < STEP_CNT);
  end

  assign busy = (state == ST_BUSY);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state     <= ST_IDLE;
      bitCnt    <= '0;
      sdaOutLow <= 1'b0;
      wcBlock   <= 1'b0;
      lastAck   <= 1'b0;
      busyCnt   <= '0;
    end else if (state == ST_BUSY) begin
      sdaOutLow <= 1'b0;
      if (busyCnt == LAST_CNT) begin
        state   <= ST_IDLE;
        busyCnt <= '0;
      end else begin
        busyCnt <= busyCnt + 1'b1;
      end
    end else if (busEv.start) begin
      state     <= ST_SEL;
      bitCnt    <= '0;
      sdaOutLow <= 1'b0;
      wcBlock   <= wcIn;
      lastAck   <= 1'b0;
    end else if (busEv.stop) begin
      sdaOutLow <= 1'b0;
      if ((state == ST_DATA) && (bitCnt == 4'd1) && lastAck) begin
        state   <= ST_BUSY;
        busyCnt <= '0;
      end else begin
        state <= ST_IDLE;
      end
    end else if (inFrame) begin
      if (((state == ST_SEL) || (state == ST_ADDR)) && wcIn) wcBlock <= 1'b1;
      if (busEv.sclRise && (bitCnt < 4'd8)) bitCnt <= bitCnt + 1'b1;
      if (byteDone) begin
        bitCnt    <= 4'd9;
        sdaOutLow <= ackNext;
        unique case (state)
          ST_SEL:  state <= selOk ? ST_ADDR : ST_IDLE;
          ST_ADDR: state <= ST_DATA;
          default: lastAck <= ackNext;
        endcase
      end
      if (ackDone) begin
        bitCnt    <= '0;
        sdaOutLow <= 1'b0;
      end
    end
  end

endmodule

// File: rtl/eepromPageWriter.sv
module eepromPageWriter
  import eeprom_wr_pkg::*;
#(
  parameter int         ADDR_W       = 10,
  parameter int         PAGE_BYTES   = 16,
  parameter int         WRITE_CYCLES = 625000,
  parameter logic [3:0] DEV_CODE     = 4'b1010
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              sclIn,
  input  logic              sdaIn,
  input  logic              wcIn,
  output logic              sdaOutLow,
  output logic              busy,
  output logic              memWe,
  output logic [ADDR_W-1:0] memAddr,
  output logic [7:0]        memData
);
  busEv_t     busEv;
  dpStrobe_t  strobe;
  logic [7:0] rxByte;

  eepromWrDatapath #(
    .ADDR_W    (ADDR_W),
    .PAGE_BYTES(PAGE_BYTES)
  ) u_dp (
    .clk    (clk),
    .rstN   (rstN),
    .sclIn  (sclIn),
    .sdaIn  (sdaIn),
    .strobe (strobe),
    .busEv  (busEv),
    .rxByte (rxByte),
    .memWe  (memWe),
    .memAddr(memAddr),
    .memData(memData)
  );

  eepromWrControl #(
    .WRITE_CYCLES(WRITE_CYCLES),
    .PAGE_BYTES  (PAGE_BYTES),
    .DEV_CODE    (DEV_CODE)
  ) u_ctl (
    .clk      (clk),
    .rstN     (rstN),
    .busEv    (busEv),
    .rxByte   (rxByte),
    .wcIn     (wcIn),
    .strobe   (strobe),
    .sdaOutLow(sdaOutLow),
    .busy     (busy)
  );

endmodule

// File: rtl/eepromPageWriterChk.sv
module eepromPageWriterChk #(
  parameter int ADDR_W       = 10,
  parameter int PAGE_BYTES   = 16,
  parameter int WRITE_CYCLES = 625000
) (
  input logic              clk,
  input logic              rstN,
  input logic              sclIn,
  input logic              sdaOutLow,
  input logic              busy,
  input logic              memWe,
  input logic [ADDR_W-1:0] memAddr
);
  localparam int OFF_W = $clog2(PAGE_BYTES);

  // length of the current busy run, counted by the checker itself
  logic [31:0] runLen;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) runLen <= '0;
    else if (busy) runLen <= runLen + 1;
    else runLen <= '0;
  end

  AST_WE_IN_BUSY: assert property (@(posedge clk) disable iff (!rstN)
    memWe |-> busy); // R4

  AST_WE_ASCENDING: assert property (@(posedge clk) disable iff (!rstN)
    memWe && $past(memWe) |-> memAddr[OFF_W-1:0] > $past(memAddr[OFF_W-1:0])); // R4

  AST_WE_SAME_PAGE: assert property (@(posedge clk) disable iff (!rstN)
    memWe && $past(memWe) |-> memAddr[ADDR_W-1:OFF_W] == $past(memAddr[ADDR_W-1:OFF_W])); // R3

  AST_SILENT_BUSY: assert property (@(posedge clk) disable iff (!rstN)
    busy |-> !sdaOutLow); // R8

  AST_BUSY_LENGTH: assert property (@(posedge clk) disable iff (!rstN)
    $fell(busy) |-> runLen == WRITE_CYCLES); // R8

  AST_PULL_SCL_LOW: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(sdaOutLow) |-> !sclIn); // R9

endmodule

bind eepromPageWriter eepromPageWriterChk #(
  .ADDR_W      (ADDR_W),
  .PAGE_BYTES  (PAGE_BYTES),
  .WRITE_CYCLES(WRITE_CYCLES)
) u_chk (
  .clk      (clk),
  .rstN     (rstN),
  .sclIn    (sclIn),
  .sdaOutLow(sdaOutLow),
  .busy     (busy),
  .memWe    (memWe),
  .memAddr  (memAddr)
);

// File: tb/eepromPageWriter_tb.sv
module eepromPageWriter_tb;
  localparam int WC_T = 600;
  localparam int Q    = 10;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic sclM = 1'b1;
  logic sdaM = 1'b1;
  logic wc = 1'b0;
  logic sdaOutLow, busy, memWe;
  logic [9:0] memAddr;
  logic [7:0] memData;
  logic sdaBus;

  assign sdaBus = sdaM & ~sdaOutLow;

  always #4 clk = ~clk;

  eepromPageWriter #(.WRITE_CYCLES(WC_T)) u_dut (
    .clk(clk), .rstN(rstN), .sclIn(sclM), .sdaIn(sdaBus), .wcIn(wc),
    .sdaOutLow(sdaOutLow), .busy(busy), .memWe(memWe),
    .memAddr(memAddr), .memData(memData)
  );

  typedef struct { logic [9:0] a; logic [7:0] d; } wr_t;
  wr_t expQ[$];

  int checks = 0;
  int errors = 0;
  int runCnt = 0;
  int lastLen = 0;
  bit finished = 0;

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // monitor: every write strobe must match the head of the queue
  always @(negedge clk) begin
    if (rstN && memWe) begin
      if (expQ.size() == 0) begin
        check(1'b0, "R4", "unexpected array write", int'(memAddr), 0);
      end else begin
        wr_t e;
        e = expQ.pop_front();
        check(memAddr == e.a, "R4", "write address", int'(memAddr), int'(e.a));
        check(memData == e.d, "R3", "write data", int'(memData), int'(e.d));
      end
    end
  end

  // busy run length
  always @(negedge clk) begin
    if (busy) runCnt++;
    else begin
      if (runCnt != 0) lastLen = runCnt;
      runCnt = 0;
    end
  end

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic i2cStart();
    sdaM = 1'b1; sclM = 1'b1; tick(Q);
    sdaM = 1'b0; tick(Q);
    sclM = 1'b0; tick(Q);
  endtask

  task automatic i2cStop();
    sdaM = 1'b0; tick(Q);
    sclM = 1'b1; tick(Q);
    sdaM = 1'b1; tick(Q);
  endtask

  task automatic sendBits(input logic [7:0] b, input int n);
    for (int i = 7; i >= 8 - n; i--) begin
      sdaM = b[i]; tick(Q);
      sclM = 1'b1; tick(2 * Q);
      sclM = 1'b0; tick(Q);
    end
  endtask

  task automatic sendByte(input logic [7:0] b, output bit ackSeen);
    sendBits(b, 8);
    sdaM = 1'b1; tick(Q);
    sclM = 1'b1; tick(Q);
    ackSeen = (sdaBus == 1'b0);
    tick(Q);
    sclM = 1'b0; tick(Q);
  endtask

  task automatic waitIdle();
    while (busy) tick(1);
    tick(3);
    check(lastLen == WC_T, "R8", "busy length", lastLen, WC_T);
    check(expQ.size() == 0, "R4", "writes left pending", expQ.size(), 0);
  endtask

  function automatic logic [7:0] dataOf(input logic [7:0] seed, input int i);
    return seed + 8'(i * 13);
  endfunction

  // full write transfer; wcHdr holds write control high through the header
  task automatic writeTxn(input logic [7:0] sel, input logic [7:0] a, input int n,
                          input logic [7:0] seed, input bit wcHdr, input string req);
    bit ack;
    bit vld[16];
    logic [7:0] img[16];
    logic [3:0] off;
    wr_t e;
    wc = wcHdr;
    i2cStart();
    sendByte(sel, ack);
    check(ack == 1'b1, "R1", "select ack", ack, 1);
    sendByte(a, ack);
    check(ack == 1'b1, "R2", "address ack", ack, 1);
    wc = 1'b0;
    off = a[3:0];
    for (int k = 0; k < 16; k++) vld[k] = 1'b0;
    for (int i = 0; i < n; i++) begin
      sendByte(dataOf(seed, i), ack);
      check(ack == !wcHdr, wcHdr ? "R6" : req, "data ack", ack, int'(!wcHdr));
      img[off] = dataOf(seed, i);
      vld[off] = 1'b1;
      off = off + 1'b1;
    end
    if (!wcHdr) begin
      for (int k = 0; k < 16; k++) begin
        if (vld[k]) begin
          e.a = {sel[2:1], a[7:4], 4'(k)};
          e.d = img[k];
          expQ.push_back(e);
        end
      end
    end
    i2cStop();
    check(busy == !wcHdr, wcHdr ? "R6" : "R4", "busy after stop", busy, int'(!wcHdr));
    if (!wcHdr) waitIdle();
    else begin
      tick(50);
      check(busy == 1'b0, "R6", "no programming period", busy, 0);
    end
  endtask

  initial begin
    bit ack;
    wr_t e;
    tick(5);
    check(busy == 1'b0, "R9", "reset busy", busy, 0);
    check(sdaOutLow == 1'b0, "R9", "reset pull", sdaOutLow, 0);
    check(memWe == 1'b0, "R9", "reset write strobe", memWe, 0);
    rstN = 1'b1;
    tick(5);

    // single byte write, select bit 3 set (ignored), block bits 2'b10
    writeTxn(8'hAC, 8'h35, 1, 8'hA5, 1'b0, "R3");

    // short page write
    writeTxn(8'hA2, 8'h7C, 3, 8'h11, 1'b0, "R3");

    // wrapping page write: 18 bytes from offset 14
    writeTxn(8'hA6, 8'h4E, 18, 8'h40, 1'b0, "R3");

    // select byte sent during programming period is refused
    wc = 1'b0;
    i2cStart();
    sendByte(8'hA0, ack);
    check(ack == 1'b1, "R1", "select ack", ack, 1);
    sendByte(8'h10, ack);
    check(ack == 1'b1, "R2", "address ack", ack, 1);
    sendByte(8'h5A, ack);
    check(ack == 1'b1, "R3", "data ack", ack, 1);
    e.a = 10'h010; e.d = 8'h5A; expQ.push_back(e);
    i2cStop();
    check(busy == 1'b1, "R4", "busy after stop", busy, 1);
    tick(5);
    i2cStart();
    sendByte(8'hA0, ack);
    check(ack == 1'b0, "R8", "select ack while busy", ack, 0);
    i2cStop();
    waitIdle();

    // wrong device code, then following byte also ignored
    i2cStart();
    sendByte(8'hB0, ack);
    check(ack == 1'b0, "R1", "wrong code ack", ack, 0);
    sendByte(8'h20, ack);
    check(ack == 1'b0, "R1", "byte after refusal", ack, 0);
    i2cStop();
    tick(20);
    check(busy == 1'b0, "R1", "busy after refusal", busy, 0);

    // read direction refused
    i2cStart();
    sendByte(8'hA1, ack);
    check(ack == 1'b0, "R1", "read select ack", ack, 0);
    i2cStop();
    tick(20);

    // stop right after the address acknowledge: no write
    i2cStart();
    sendByte(8'hA0, ack);
    sendByte(8'h30, ack);
    check(ack == 1'b1, "R2", "address ack", ack, 1);
    i2cStop();
    tick(20);
    check(busy == 1'b0, "R4", "stop after address", busy, 0);

    // stop in the middle of the next data byte: abort
    i2cStart();
    sendByte(8'hA0, ack);
    sendByte(8'h31, ack);
    sendByte(8'h77, ack);
    check(ack == 1'b1, "R3", "data ack", ack, 1);
    sendBits(8'hC3, 4);
    i2cStop();
    tick(50);
    check(busy == 1'b0, "R5", "stop mid-byte", busy, 0);

    // repeated start after an acked data byte: abort
    i2cStart();
    sendByte(8'hA0, ack);
    sendByte(8'h32, ack);
    sendByte(8'h78, ack);
    i2cStart();
    i2cStop();
    tick(50);
    check(busy == 1'b0, "R5", "stop after restart", busy, 0);

    // write control held high through the header
    writeTxn(8'hA4, 8'h50, 2, 8'h99, 1'b1, "R6");

    // write control pulsed only during the select byte
    i2cStart();
    sendBits(8'hA0, 3);
    wc = 1'b1; tick(Q);
    wc = 1'b0;
    sdaM = 1'b1; tick(Q);
    sclM = 1'b1; tick(Q);
    ack = (sdaBus == 1'b0); tick(Q);
    sclM = 1'b0; tick(Q);
    check(ack == 1'b0, "R1", "mid-select pause sample", ack, 0);
    i2cStop();
    tick(20);
    i2cStart();
    sendBits(8'hA0, 3);
    wc = 1'b1;
    sendBits(8'hA0 << 3, 5);
    wc = 1'b0;
    sdaM = 1'b1; tick(Q); sclM = 1'b1; tick(Q);
    ack = (sdaBus == 1'b0); tick(Q); sclM = 1'b0; tick(Q);
    check(ack == 1'b1, "R1", "select ack", ack, 1);
    sendByte(8'h60, ack);
    sendByte(8'h01, ack);
    check(ack == 1'b0, "R6", "data ack after pulse", ack, 0);
    i2cStop();
    tick(50);
    check(busy == 1'b0, "R6", "no write after pulse", busy, 0);

    // write control raised only during data: no effect
    i2cStart();
    sendByte(8'hA2, ack);
    sendByte(8'h91, ack);
    wc = 1'b1;
    sendByte(8'h3C, ack);
    check(ack == 1'b1, "R7", "data ack with late control", ack, 1);
    e.a = 10'h191; e.d = 8'h3C; expQ.push_back(e);
    i2cStop();
    wc = 1'b0;
    check(busy == 1'b1, "R7", "busy after late control", busy, 1);
    waitIdle();

    check(expQ.size() == 0, "R4", "final queue", expQ.size(), 0);
    if (!finished) begin
      finished = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      checks++;
      errors++;
      $display("FAIL watchdog: run did not finish actual=0 expected=1");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule